// File: doc/BRIEF.md
# Fused Idiom Integer Execution Unit

This unit executes the single operations that a front end issues in place of two adjacent integer instructions that it has merged. It takes a 5-bit operation code and two 64-bit operands, and it returns one 64-bit result in the same cycle. It has no clock, no reset and no internal state.

The operations fall into four groups. The first group adds a shifted copy of the first operand to the second operand, with a left shift of 1 to 4 or a logical right shift of 29 to 32. The second group zero-extends the low word of the first operand and then shifts it left by 1 to 3. The third group takes a single bit or a single byte: it can extract byte 1, add the parity bit of the first operand, or clear the low byte of the first operand and then OR in the second operand. The fourth group takes a 32-bit add, or a bitwise AND, OR, XOR or per-byte OR-combine, and narrows the outcome to 1, 8 or 16 bits. Plain zero-extend word, zero-extend half and sign-extend half of the first operand are also provided.

In all the formulas below, `a` is the first operand and `b` is the second operand.

Top module: `fused_alu`

## Requirements
- R1: Codes 4, 5, 6 and 7 return `(a << k) + b`, with k equal to 1, 2, 3 and 4 respectively. The sum wraps at 64 bits.
- R2: Codes 12, 13, 14 and 15 return `(a >> k) + b`, where `>>` is a logical shift and k equals 29, 30, 31 and 32 respectively. The sum wraps at 64 bits.
- R3: Codes 8, 9 and 10 take `a[31:0]`, zero-extend it to 64 bits and then shift it left by 1, 2 and 3 respectively.
- R4: Code 11 returns `a[15:8]` zero-extended to 64 bits.
- R5: Code 16 returns `(a & 1) + b` over 64 bits. Code 17 computes the same sum, keeps its low 32 bits and sign-extends them from bit 31.
- R6: Code 18 returns `{a[63:8], 8'h00} | b`.
- R7: Codes 19, 20, 21 and 22 first form the 32-bit sum `s = a[31:0] + b[31:0]`. They then return, in order: `s[7:0]` zero-extended, `s[0]` zero-extended, `s[15:0]` zero-extended, and `s[15:0]` sign-extended.
- R8: Codes 23 to 26 return bit 0 of the logic result, zero-extended. Codes 27 to 30 return the low 16 bits of the logic result, zero-extended. Within each group of four, the logic functions come in this order: `a & b`, `a | b`, `a ^ b`, and orc.b of `a`. For orc.b, each byte of the result is 0xFF when any bit of the matching byte of `a` is set, and 0x00 otherwise.
- R9: Code 1 returns `a[31:0]` zero-extended. Code 2 returns `a[15:0]` zero-extended. Code 3 returns `a[15:0]` sign-extended.
- R10: Codes 0 and 31 are undefined, and each returns a result of zero.
- R11: For codes 26 and 30, the value of `b` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| result | output | 64 | Result of the selected operation |

## Verification
The immediate assertions are evaluated on every input change. They check the shape of each result: undefined codes give zero, the narrowing codes leave the upper bits clear or sign-filled, the zero-extend-and-shift codes leave their high and low bits clear, and the word-sized add is sign-extended. The actual arithmetic values can only be shown by the bench. It compares every code against a behavioural model, using corner operands (all ones, zero, bit 31 set, bit 15 set) and random operands. The bench also shows that the orc.b variants ignore the second operand, by applying two different values of it and comparing the results.

// File: rtl/fused_alu_pkg.sv
// Package fused_alu_pkg
// Holds the shared operation code type. Code values are fixed because the
// issuing decoder produces them; any value not listed is treated as undefined.
package fused_alu_pkg;
    typedef enum logic [4:0] {
        OP_NONE    = 5'd0,
        OP_ZEXTW   = 5'd1,  OP_ZEXTH   = 5'd2,  OP_SEXTH   = 5'd3,
        OP_SHL1ADD = 5'd4,  OP_SHL2ADD = 5'd5,  OP_SHL3ADD = 5'd6,  OP_SHL4ADD = 5'd7,
        OP_ZWSHL1  = 5'd8,  OP_ZWSHL2  = 5'd9,  OP_ZWSHL3  = 5'd10,
        OP_BYTE1   = 5'd11,
        OP_SR29ADD = 5'd12, OP_SR30ADD = 5'd13, OP_SR31ADD = 5'd14, OP_SR32ADD = 5'd15,
        OP_PARADD  = 5'd16, OP_PARADDW = 5'd17, OP_ORMASK  = 5'd18,
        OP_ADDW_B8 = 5'd19, OP_ADDW_B1 = 5'd20, OP_ADDW_ZH = 5'd21, OP_ADDW_SH = 5'd22,
        OP_AND_B1  = 5'd23, OP_OR_B1   = 5'd24, OP_XOR_B1  = 5'd25, OP_ORC_B1  = 5'd26,
        OP_AND_ZH  = 5'd27, OP_OR_ZH   = 5'd28, OP_XOR_ZH  = 5'd29, OP_ORC_ZH  = 5'd30,
        OP_RSVD    = 5'd31
    } fuse_op_e;
endpackage

// File: rtl/fused_arith.sv
// Module fused_arith
// Handles the shift-add, zero-extend-shift, extract, parity-add, masked-OR and
// plain extend operations. Drives zero when op is not one of its codes.
// Assumes XLEN is 64 (word = XLEN/2, half = 16 bits).
module fused_arith
    import fused_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  fuse_op_e          op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam int WORD = XLEN / 2;
    localparam int NSH  = 4;
    localparam int SRB  = 29;

    logic [XLEN-1:0] shl_add [NSH];
    logic [XLEN-1:0] srl_add [NSH];
    logic [XLEN-1:0] zw;
    logic [XLEN-1:0] par_sum;

    // One left-shift adder and one right-shift adder per shift amount
    for (genvar gi = 0; gi < NSH; gi++) begin : g_shadd
        assign shl_add[gi] = (a << (gi + 1)) + b;
        assign srl_add[gi] = (a >> (SRB + gi)) + b;
    end

    assign zw      = {{WORD{1'b0}}, a[WORD-1:0]};
    assign par_sum = {{(XLEN-1){1'b0}}, a[0]} + b;

    // Select this group's result by operation code
    always_comb begin
        case (op)
            OP_ZEXTW:   res = zw;
            OP_ZEXTH:   res = {{(XLEN-16){1'b0}}, a[15:0]};
            OP_SEXTH:   res = {{(XLEN-16){a[15]}}, a[15:0]};
            OP_SHL1ADD: res = shl_add[0];
            OP_SHL2ADD: res = shl_add[1];
            OP_SHL3ADD: res = shl_add[2];
            OP_SHL4ADD: res = shl_add[3];
            OP_ZWSHL1:  res = zw << 1;
            OP_ZWSHL2:  res = zw << 2;
            OP_ZWSHL3:  res = zw << 3;
            OP_BYTE1:   res = {{(XLEN-8){1'b0}}, a[15:8]};
            OP_SR29ADD: res = srl_add[0];
            OP_SR30ADD: res = srl_add[1];
            OP_SR31ADD: res = srl_add[2];
            OP_SR32ADD: res = srl_add[3];
            OP_PARADD:  res = par_sum;
            OP_PARADDW: res = {{WORD{par_sum[WORD-1]}}, par_sum[WORD-1:0]};
            OP_ORMASK:  res = {a[XLEN-1:8], 8'h00} | b;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/fused_narrow.sv
// Module fused_narrow
// Handles the word-add and logic operations that are narrowed to 1, 8 or 16
// bits. Drives zero when op is not one of its codes. Assumes XLEN is 64.
module fused_narrow
    import fused_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  fuse_op_e          op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam int WORD   = XLEN / 2;
    localparam int NBYTES = XLEN / 8;

    logic [WORD-1:0] wsum;
    logic [XLEN-1:0] orc;
    logic [XLEN-1:0] lres;

    assign wsum = a[WORD-1:0] + b[WORD-1:0];

    // Per-byte OR-combine of a
    for (genvar gb = 0; gb < NBYTES; gb++) begin : g_orc
        assign orc[gb*8 +: 8] = {8{|a[gb*8 +: 8]}};
    end

    // Pick the logic function for the narrowing codes
    always_comb begin
        case (op)
            OP_AND_B1, OP_AND_ZH: lres = a & b;
            OP_OR_B1,  OP_OR_ZH:  lres = a | b;
            OP_XOR_B1, OP_XOR_ZH: lres = a ^ b;
            default:              lres = orc;
        endcase
    end

    // Narrow the add or logic outcome
    always_comb begin
        case (op)
            OP_ADDW_B8: res = {{(XLEN-8){1'b0}}, wsum[7:0]};
            OP_ADDW_B1: res = {{(XLEN-1){1'b0}}, wsum[0]};
            OP_ADDW_ZH: res = {{(XLEN-16){1'b0}}, wsum[15:0]};
            OP_ADDW_SH: res = {{(XLEN-16){wsum[15]}}, wsum[15:0]};
            OP_AND_B1, OP_OR_B1, OP_XOR_B1, OP_ORC_B1:
                        res = {{(XLEN-1){1'b0}}, lres[0]};
            OP_AND_ZH, OP_OR_ZH, OP_XOR_ZH, OP_ORC_ZH:
                        res = {{(XLEN-16){1'b0}}, lres[15:0]};
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/fused_alu.sv
// Module fused_alu
// Combinational unit for operations fused from instruction pairs. The two
// groups each drive zero outside their own codes, so the top ORs them.
// Assumes XLEN is 64; there is no clock or reset.
module fused_alu
    import fused_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0]      op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result
);
    localparam int WORD = XLEN / 2;

    fuse_op_e        op;
    logic [XLEN-1:0] arith_res;
    logic [XLEN-1:0] narrow_res;

    assign op = fuse_op_e'(op_sel);

    fused_arith #(.XLEN(XLEN)) u_arith (.op(op), .a(src_a), .b(src_b), .res(arith_res));
    fused_narrow #(.XLEN(XLEN)) u_narrow (.op(op), .a(src_a), .b(src_b), .res(narrow_res));

    // Merge the two group outputs
    assign result = arith_res | narrow_res;

    // Shape checks on the merged output
    always_comb begin
        if (op == OP_NONE || op == OP_RSVD)
            a_r10_undef_zero: assert (result == '0);
        if (op >= OP_AND_B1 && op <= OP_ORC_B1)
            a_r8_bit_narrow: assert (result[XLEN-1:1] == '0);
        if (op >= OP_AND_ZH && op <= OP_ORC_ZH)
            a_r8_half_narrow: assert (result[XLEN-1:16] == '0);
        if (op == OP_ADDW_SH)
            a_r7_half_sext: assert (result[XLEN-1:16] == {(XLEN-16){result[15]}});
        if (op == OP_ADDW_B8)
            a_r7_byte_zext: assert (result[XLEN-1:8] == '0);
        if (op == OP_ZWSHL3)
            a_r3_zw_window: assert (result[XLEN-1:WORD+3] == '0 && result[2:0] == 3'b0);
        if (op == OP_PARADDW)
            a_r5_word_sext: assert (result[XLEN-1:WORD] == {WORD{result[WORD-1]}});
        if (op == OP_BYTE1)
            a_r4_byte_extract: assert (result == {{(XLEN-8){1'b0}}, src_a[15:8]});
    end
endmodule

// File: tb/fused_alu_bench.sv
module fused_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel;
    logic [63:0] src_a, src_b;
    logic [63:0] result;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fused_alu u_fused_alu (.op_sel(op_sel), .src_a(src_a), .src_b(src_b), .result(result));

    function automatic string req_of(int op);
        if (op == 0 || op == 31) return "R10";
        if (op <= 3) return "R9";
        if (op <= 7) return "R1";
        if (op <= 10) return "R3";
        if (op == 11) return "R4";
        if (op <= 15) return "R2";
        if (op <= 17) return "R5";
        if (op == 18) return "R6";
        if (op <= 22) return "R7";
        return "R8";
    endfunction

    function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b);
        logic [63:0] lg;
        logic [31:0] w;
        logic [63:0] s;
        w = a[31:0] + b[31:0];
        case ((op - 23) % 4)
            0: lg = a & b;
            1: lg = a | b;
            2: lg = a ^ b;
            default: begin
                lg = 0;
                for (int i = 0; i < 8; i++) if (((a >> (8*i)) & 64'hFF) != 0) lg |= 64'hFF << (8*i);
            end
        endcase
        case (op)
            1: return a & 64'hFFFF_FFFF;
            2: return a & 64'hFFFF;
            3: return 64'($signed(a[15:0]));
            4, 5, 6, 7: return a * (64'd1 << (op - 3)) + b;
            8, 9, 10: return (a & 64'hFFFF_FFFF) * (64'd1 << (op - 7));
            11: return (a / 256) % 256;
            12, 13, 14, 15: return (a >> (op + 17)) + b;
            16: return (a % 2) + b;
            17: begin s = (a % 2) + b; return 64'($signed(s[31:0])); end
            18: return (a & ~64'hFF) | b;
            19: return {56'b0, w[7:0]};
            20: return {63'b0, w[0]};
            21: return {48'b0, w[15:0]};
            22: return 64'($signed(w[15:0]));
            23, 24, 25, 26: return lg & 64'h1;
            27, 28, 29, 30: return lg & 64'hFFFF;
            default: return 64'h0;
        endcase
    endfunction

    task automatic apply(int op, logic [63:0] a, logic [63:0] b);
        logic [63:0] exp;
        @(negedge clk);
        op_sel = op[4:0];
        src_a = a;
        src_b = b;
        exp = model(op, a, b);
        @(posedge clk);
        #1;
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req_of(op), op, a, b, result, exp);
        end
    endtask

    // R11: orc.b variants must give the same result for two different b
    task automatic check_ignore(int op, logic [63:0] a);
        logic [63:0] r1;
        @(negedge clk);
        op_sel = op[4:0]; src_a = a; src_b = 64'h0;
        @(posedge clk); #1;
        r1 = result;
        @(negedge clk);
        src_b = 64'hFFFF_FFFF_FFFF_FFFF;
        @(posedge clk); #1;
        total++;
        if (result !== r1) begin
            bad++;
            $display("FAIL R11 op=%0d actual=%h expected=%h", op, result, r1);
        end
    endtask

    logic [63:0] corners [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000,
                                 64'h0000_0000_0000_8000, 64'h1234_5678_9ABC_DEF1,
                                 64'h7FFF_FFFF_0000_00FF};

    initial begin
        op_sel = 5'd0; src_a = '0; src_b = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state check: code 0 with zero operands gives zero (R10)
        apply(0, 64'h0, 64'h0);
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply(op, corners[i], corners[j]);
            for (int k = 0; k < 40; k++)
                apply(op, {$urandom, $urandom}, {$urandom, $urandom});
        end
        // R11: src_b ignored for orc.b narrowing
        for (int i = 0; i < 6; i++) begin
            check_ignore(26, corners[i]);
            check_ignore(30, corners[i]);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule